// File: doc/BRIEF.md
# Coherence Invalidation Inbox with Barrier Drain

This block sits on a core's incoming coherence path. Invalidation probes from the interconnect go into a small FIFO. Each probe is acknowledged to its sender as soon as it is accepted, which is before the local tag array has dropped the line. The FIFO then feeds the tag array one entry at a time through a valid/ready handshake, at whatever rate the array can take.

Read-data replies do not pass through the FIFO. They go to the core through a single register stage, so a reply can reach the core ahead of invalidations that arrived earlier. While such an invalidation is still queued, a local read of that line can return stale data.

Order is restored only by a barrier. When the core issues a barrier, the block counts how many invalidations are queued at that moment. It signals completion once all of those entries have been handed to the tag array. Probes that arrive after the barrier do not extend the wait. Only one barrier can be open at a time.

Top module: `probe_inbox`

## Requirements
- R1: After reset the queue is empty. `inv_ready` and `bar_ready` are 1. `inv_ack`, `tag_valid`, `bar_done` and `core_rsp_valid` are 0.
- R2: In the cycle after a probe is accepted (`inv_valid` and `inv_ready` both 1 at a clock edge), `inv_ack` is 1. This holds even while the entry is still waiting for the tag array.
- R3: Queued lines are presented on `tag_line` in the order in which they were accepted.
- R4: The queue holds 8 entries. With 8 entries held and no entry leaving, `inv_ready` is 0. A probe offered then is not taken, and `inv_ack` stays 0 in the following cycle.
- R5: At most one entry leaves per clock, on `tag_valid` and `tag_ready` both 1. While `tag_valid` is 1 and `tag_ready` is 0, `tag_valid` stays 1 and `tag_line` holds its value.
- R6: A reply with `rsp_valid` 1 appears on `core_rsp_valid`/`core_rsp_data` in the next cycle, whatever the queue holds.
- R7: A barrier is accepted when `bar_valid` and `bar_ready` are both 1 at an edge. Its `bar_done` pulse is 1 for exactly one cycle: the cycle after the last hand-off of every entry queued at acceptance. If the queue was empty at acceptance, that cycle is the one after acceptance.
- R8: Probes accepted at or after the barrier's acceptance edge do not delay its `bar_done`.
- R9: From the cycle after a barrier is accepted until its `bar_done` cycle, inclusive, `bar_ready` is 0. A second request is held off during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_valid | input | 1 | Invalidation probe offered |
| inv_line | input | LINE_W | Line address of the probe |
| inv_ready | output | 1 | Queue can take a probe |
| inv_ack | output | 1 | Acknowledge to sender, one cycle after acceptance |
| rsp_valid | input | 1 | Read reply from interconnect |
| rsp_data | input | DATA_W | Reply payload |
| core_rsp_valid | output | 1 | Reply forwarded to core |
| core_rsp_data | output | DATA_W | Forwarded payload |
| tag_valid | output | 1 | Invalidation offered to tag array |
| tag_line | output | LINE_W | Line to invalidate |
| tag_ready | input | 1 | Tag array takes the invalidation |
| bar_valid | input | 1 | Barrier request from core |
| bar_ready | output | 1 | No barrier open; request can be taken |
| bar_done | output | 1 | Barrier complete pulse |

## Verification
The in-line properties watch the fixed timing rules on every cycle:
- the acknowledge after each acceptance,
- the one-cycle reply bypass,
- a stalled head staying put,
- the barrier port closing while a barrier is open.

Only the bench scenarios can show the rest: FIFO order across a full queue, refusal at capacity, and `bar_done` landing exactly after the snapshot entries drain. They also show that a probe accepted mid-drain is not counted, and that a held second barrier snapshots only the leftover entry.

// File: rtl/probe_pkg.sv
// probe_pkg: default sizes shared by the inbox and its bench.
// Assumes: nothing; pure constants.
package probe_pkg;
    parameter int unsigned INBOX_DEPTH = 8;
    parameter int unsigned INBOX_LINE_W = 16;
    parameter int unsigned INBOX_DATA_W = 32;
endpackage

// File: rtl/probe_fifo.sv
// probe_fifo: circular buffer holding pending invalidations.
// Assumes: DEPTH is a power of two; caller never writes when full
// and never reads when empty.
module probe_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 16,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
            cnt <= cnt + CW'(wr_en) - CW'(rd_en);
        end
    end

    // Status outputs.
    always_comb begin
        rd_data = mem[rp];
        full    = (cnt == CW'(DEPTH));
        empty   = (cnt == '0);
        level   = cnt;
    end

    // R4: capacity never exceeded.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    // R5: never read from an empty buffer.
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);
endmodule

// File: rtl/barrier_tracker.sv
// barrier_tracker: snapshots queue occupancy at barrier acceptance and
// counts hand-offs down to zero, then pulses done for one cycle.
// Assumes: pop is 1 only when the queue is non-empty.
module barrier_tracker #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [CW-1:0] level,
    input  logic          pop,
    output logic          done
);
    logic          open_q;
    logic [CW-1:0] remain;

    // Completion and request-accept decode.
    always_comb begin
        done      = open_q && (remain == '0);
        req_ready = !open_q;
    end

    // Open/close the barrier and track entries still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            remain <= '0;
        end else if (!open_q) begin
            if (req_valid) begin
                open_q <= 1'b1;
                remain <= level - CW'(pop);
            end
        end else if (done) begin
            open_q <= 1'b0;
        end else if (pop) begin
            remain <= remain - 1'b1;
        end
    end

    // R9: accepted barrier closes the request port next cycle.
    a_r9_single_open: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R9: done only while the port is closed.
    a_r9_done_closed: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    // R7: done lasts a single cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/reply_bypass.sv
// reply_bypass: one register stage carrying read replies to the core,
// independent of the invalidation queue.
// Assumes: the core always accepts a reply.
module reply_bypass #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    // Register the reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

    // R6: every reply reaches the core one cycle later.
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/probe_inbox.sv
// probe_inbox: incoming coherence path. Queues invalidations with early
// acknowledge, feeds them to the tag array, bypasses replies, and
// completes barriers once the snapshot of queued entries has drained.
// Assumes: sender honours inv_ready; core holds bar_valid until taken.
module probe_inbox
    import probe_pkg::*;
#(
    parameter int unsigned DEPTH  = INBOX_DEPTH,
    parameter int unsigned LINE_W = INBOX_LINE_W,
    parameter int unsigned DATA_W = INBOX_DATA_W,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_valid,
    input  logic [LINE_W-1:0] inv_line,
    output logic              inv_ready,
    output logic              inv_ack,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              core_rsp_valid,
    output logic [DATA_W-1:0] core_rsp_data,
    output logic              tag_valid,
    output logic [LINE_W-1:0] tag_line,
    input  logic              tag_ready,
    input  logic              bar_valid,
    output logic              bar_ready,
    output logic              bar_done
);
    logic          push, pop, full, empty;
    logic [CW-1:0] level;

    // Handshake decode at both queue ends.
    always_comb begin
        inv_ready = !full;
        push      = inv_valid && !full;
        tag_valid = !empty;
        pop       = tag_valid && tag_ready;
    end

    // Early acknowledge: one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) inv_ack <= 1'b0;
        else        inv_ack <= push;
    end

    probe_fifo #(.DEPTH(DEPTH), .W(LINE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push), .wr_data(inv_line),
        .rd_en(pop), .rd_data(tag_line),
        .full(full), .empty(empty), .level(level)
    );

    barrier_tracker #(.CW(CW)) u_bar (
        .clk(clk), .rst_n(rst_n),
        .req_valid(bar_valid), .req_ready(bar_ready),
        .level(level), .pop(pop), .done(bar_done)
    );

    reply_bypass #(.DW(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rsp_valid), .in_data(rsp_data),
        .out_valid(core_rsp_valid), .out_data(core_rsp_data)
    );

    // R2: acceptance is acknowledged next cycle.
    a_r2_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready) |=> inv_ack);
    // R4: refused probe gets no acknowledge.
    a_r4_no_ack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_ready && !pop) |=> !inv_ack);
    // R5: stalled head holds its line.
    a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !tag_ready) |=> (tag_valid && $stable(tag_line)));
endmodule

// File: tb/sim_probe_inbox.sv
// sim_probe_inbox: directed bench for probe_inbox. Inputs change at the
// falling edge; outputs are sampled 1 ns later.
module sim_probe_inbox;
    localparam int unsigned LW = 16;
    localparam int unsigned DW = 32;
    localparam logic [LW-1:0] VEC [8] = '{16'h1A00, 16'h2B40, 16'h3C80, 16'h4DC0,
                                          16'h5E00, 16'h6F40, 16'h7080, 16'h81C0};
    localparam logic [LW-1:0] LATE = 16'h0550;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_valid = 1'b0;
    logic [LW-1:0] inv_line = '0;
    logic          inv_ready, inv_ack;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          core_rsp_valid;
    logic [DW-1:0] core_rsp_data;
    logic          tag_valid;
    logic [LW-1:0] tag_line;
    logic          tag_ready = 1'b0;
    logic          bar_valid = 1'b0;
    logic          bar_ready, bar_done;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    always #10 clk = ~clk;

    probe_inbox u0 (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_line(inv_line), .inv_ready(inv_ready), .inv_ack(inv_ack),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data),
        .tag_valid(tag_valid), .tag_line(tag_line), .tag_ready(tag_ready),
        .bar_valid(bar_valid), .bar_ready(bar_ready), .bar_done(bar_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge, then settle.
    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) nxt();
        rst_n = 1'b1;
        nxt();
        // R1 reset state
        chk("R1 inv_ready", inv_ready, 1);
        chk("R1 bar_ready", bar_ready, 1);
        chk("R1 inv_ack", inv_ack, 0);
        chk("R1 tag_valid", tag_valid, 0);
        chk("R1 bar_done", bar_done, 0);
        chk("R1 core_rsp_valid", core_rsp_valid, 0);

        // Table walk: fill queue with a stalled tag array, replies alongside.
        for (int i = 0; i < 8; i++) begin
            inv_valid = 1'b1;
            inv_line  = VEC[i];
            rsp_valid = 1'b1;
            rsp_data  = 32'hD000_0000 + 32'(i);
            #1;
            chk("R4 not full yet", inv_ready, 1);
            nxt();
            inv_valid = 1'b0;
            rsp_valid = 1'b0;
            #1;
            chk("R2 ack", inv_ack, 1);
            chk("R6 reply valid", core_rsp_valid, 1);
            chk("R6 reply data", core_rsp_data, 32'hD000_0000 + 32'(i));
            chk("R5 head held", tag_line, VEC[0]);
            chk("R5 valid held", tag_valid, 1);
        end

        // R4 full queue refuses.
        inv_valid = 1'b1;
        inv_line  = 16'hFFFF;
        #1;
        chk("R4 ready low", inv_ready, 0);
        nxt();
        inv_valid = 1'b0;
        #1;
        chk("R4 no ack", inv_ack, 0);

        // Barrier with eight entries queued.
        bar_valid = 1'b1;
        #1;
        chk("R9 ready before", bar_ready, 1);
        nxt();
        bar_valid = 1'b0;
        #1;
        chk("R9 closed", bar_ready, 0);
        chk("R7 not done", bar_done, 0);

        for (int k = 0; k < 8; k++) begin
            tag_ready = 1'b1;
            inv_valid = (k == 1);
            inv_line  = LATE;
            bar_valid = (k >= 2);
            #1;
            chk("R3 order", tag_line, VEC[k]);
            chk("R7 early", bar_done, 0);
            if (k >= 2) chk("R9 second held", bar_ready, 0);
            nxt();
        end
        tag_ready = 1'b0;
        inv_valid = 1'b0;
        #1;
        chk("R7 done", bar_done, 1);
        chk("R8 late entry left", tag_line, LATE);
        chk("R8 late valid", tag_valid, 1);
        chk("R9 closed at done", bar_ready, 0);
        nxt();
        // Held second barrier is taken now, snapshot = 1 entry.
        chk("R7 pulse ends", bar_done, 0);
        chk("R9 reopened", bar_ready, 1);
        nxt();
        bar_valid = 1'b0;
        tag_ready = 1'b1;
        #1;
        chk("R7 second waits", bar_done, 0);
        chk("R3 late line", tag_line, LATE);
        nxt();
        tag_ready = 1'b0;
        #1;
        chk("R7 second done", bar_done, 1);
        chk("R5 queue empty", tag_valid, 0);
        nxt();

        // R7 empty-queue barrier completes next cycle.
        bar_valid = 1'b1;
        nxt();
        bar_valid = 1'b0;
        #1;
        chk("R7 empty done", bar_done, 1);
        nxt();
        chk("R7 empty pulse", bar_done, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule